// File: doc/BRIEF.md
# Program Counter Sequencer with Two-Entry Return Stack

This block supplies the fetch address for a small processor with 12-bit instruction words. Each enabled instruction cycle moves the address forward by one, unless a decoded control strobe loads it. A jump loads nine address bits. A call, or a data write to the low byte of the counter, loads eight bits and forces bit 8 low. A return pops a two-entry stack of return addresses. In every case an external page-select input supplies bit 9.

The implemented program space is a power-of-two parameter. Counter bits at and above its address width always read zero, so any address beyond the implemented space wraps into it. The return stack has no overflow or underflow indication. A push discards the oldest entry. A pop copies the bottom entry upward, so extra returns keep going back to the same address. Reset points the counter at the last implemented word and leaves the stack untouched. After every load, a flush output marks the instruction that was already fetched so that it is discarded. A return also hands its literal byte to the working register.

Top module: `pc_sequencer`

## Requirements
- R1: `fetch_addr` is 12 bits wide. Bits at and above log2(MEM_WORDS) are always 0, so every computed address wraps modulo MEM_WORDS.
- R2: In a cycle with `cyc_en` high and no strobe, the address becomes (address + 1) mod MEM_WORDS, so MEM_WORDS-1 is followed by 0.
- R3: A jump loads bits 8:0 from `jmp_field` and bit 9 from `page_sel`, then applies the wrap of R1.
- R4: A call loads bits 7:0 from `call_field`. A low-byte write loads bits 7:0 from `pcl_data`. Both force bit 8 to 0, take bit 9 from `page_sel`, and wrap per R1.
- R5: A call moves stack entry 1 into entry 2, then stores the current `fetch_addr` (the word after the call) in entry 1. Only the two newest return addresses survive deeper nesting.
- R6: A return loads entry 1 into the address and copies entry 2 into entry 1, leaving entry 2 as it was. Every return after the second goes back to the same address as the second.
- R7: In the cycle of a return that takes effect, `wreg_we` is 1 and `wreg_lit` equals `ret_lit`. Otherwise `wreg_we` is 0.
- R8: While `rst_n` is low, `fetch_addr` is MEM_WORDS-1 and `flush` is 0. Reset leaves both stack entries unchanged.
- R9: After an enabled cycle that loads the address, `flush` is 1 for the next instruction cycle. After an enabled cycle without a load, `flush` is 0.
- R10: When several strobes are high together, call takes priority, then return, then jump, then the low-byte write. Only the winner acts.
- R11: While `cyc_en` is low, all strobes are ignored: the address, `flush` and the stack keep their values, and `wreg_we` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_en | input | 1 | Instruction-cycle enable strobe |
| page_sel | input | 1 | Page-select bit, supplies address bit 9 |
| jmp_en | input | 1 | Jump strobe |
| jmp_field | input | 9 | Jump target field |
| call_en | input | 1 | Call strobe |
| call_field | input | 8 | Call target byte |
| ret_en | input | 1 | Return-with-literal strobe |
| ret_lit | input | 8 | Literal carried by the return |
| pcl_wr_en | input | 1 | Write strobe for the counter's low byte |
| pcl_data | input | 8 | Data byte for the low-byte write |
| fetch_addr | output | 12 | Current fetch address |
| flush | output | 1 | Discard the already-fetched instruction |
| wreg_we | output | 1 | Load enable for the working register |
| wreg_lit | output | 8 | Literal for the working register |

## Verification
Two instances run side by side on the same inputs, one with 1024 words and one with 512. For every jump field and every call or write byte, both page values are tried. On the smaller instance this shows the page bit being wrapped away, while the larger one keeps it. A long run of plain increments crosses the top of both spaces and tells a correct wrap apart from a carry into the unused bits. Calls nested three deep followed by four returns, a reset between pushes and pops, and all combinations of strobes together separate the copy-down pop, the retained stack and the priority order from simpler alternatives.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
    localparam int PC_W   = 12;
    localparam int JMP_W  = 9;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        SEL_HOLD,
        SEL_INC,
        SEL_CALL,
        SEL_RET,
        SEL_JMP,
        SEL_PCL
    } sel_e;

    typedef struct packed {
        logic [PC_W-1:0] pc;
        logic            flush;
    } seq_state_t;

    typedef struct packed {
        logic [PC_W-1:0] lvl1;
        logic [PC_W-1:0] lvl2;
    } stk_state_t;
endpackage

// File: rtl/pcs_select.sv
module pcs_select
    import pcs_pkg::*;
(
    input  logic cyc_en,
    input  logic call_en,
    input  logic ret_en,
    input  logic jmp_en,
    input  logic pcl_wr_en,
    output sel_e sel
);
    // Fixed priority: call, return, jump, low-byte write.
    always_comb begin
        if (!cyc_en)        sel = SEL_HOLD;
        else if (call_en)   sel = SEL_CALL;
        else if (ret_en)    sel = SEL_RET;
        else if (jmp_en)    sel = SEL_JMP;
        else if (pcl_wr_en) sel = SEL_PCL;
        else                sel = SEL_INC;
    end
endmodule

// File: rtl/pcs_target.sv
module pcs_target
    import pcs_pkg::*;
#(
    parameter int MEM_WORDS = 1024
) (
    input  sel_e              sel,
    input  logic [PC_W-1:0]   pc_cur,
    input  logic              page_sel,
    input  logic [JMP_W-1:0]  jmp_field,
    input  logic [BYTE_W-1:0] call_field,
    input  logic [BYTE_W-1:0] pcl_data,
    input  logic [PC_W-1:0]   stk_top,
    output logic [PC_W-1:0]   pc_next
);
    localparam logic [PC_W-1:0] ADDR_MASK = PC_W'(MEM_WORDS - 1);

    logic [PC_W-1:0] raw;

    always_comb begin
        unique case (sel)
            SEL_INC:  raw = pc_cur + PC_W'(1);
            SEL_CALL: raw = PC_W'({page_sel, 1'b0, call_field});
            SEL_RET:  raw = stk_top;
            SEL_JMP:  raw = PC_W'({page_sel, jmp_field});
            SEL_PCL:  raw = PC_W'({page_sel, 1'b0, pcl_data});
            default:  raw = pc_cur;
        endcase
        pc_next = raw & ADDR_MASK;
    end
endmodule

// File: rtl/pcs_ret_stack.sv
module pcs_ret_stack
    import pcs_pkg::*;
(
    input  logic            clk,
    input  logic            push,
    input  logic            pop,
    input  logic [PC_W-1:0] push_val,
    output logic [PC_W-1:0] lvl1,
    output logic [PC_W-1:0] lvl2
);
    stk_state_t stk_d, stk_q;

    // Storage has no reset: return addresses survive a reset.
    always_comb begin
        stk_d = stk_q;
        if (push) begin
            stk_d.lvl2 = stk_q.lvl1;
            stk_d.lvl1 = push_val;
        end else if (pop) begin
            stk_d.lvl1 = stk_q.lvl2;
        end
    end

    always_ff @(posedge clk) begin
        stk_q <= stk_d;
    end

    assign lvl1 = stk_q.lvl1;
    assign lvl2 = stk_q.lvl2;
endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
    import pcs_pkg::*;
#(
    parameter int MEM_WORDS = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_en,
    input  logic              page_sel,
    input  logic              jmp_en,
    input  logic [JMP_W-1:0]  jmp_field,
    input  logic              call_en,
    input  logic [BYTE_W-1:0] call_field,
    input  logic              ret_en,
    input  logic [BYTE_W-1:0] ret_lit,
    input  logic              pcl_wr_en,
    input  logic [BYTE_W-1:0] pcl_data,
    output logic [PC_W-1:0]   fetch_addr,
    output logic              flush,
    output logic              wreg_we,
    output logic [BYTE_W-1:0] wreg_lit
);
    localparam logic [PC_W-1:0] RESET_PC = PC_W'(MEM_WORDS - 1);

    sel_e            sel;
    logic [PC_W-1:0] pc_next;
    logic [PC_W-1:0] stk_lvl1;
    logic [PC_W-1:0] stk_lvl2;
    logic            do_push;
    logic            do_pop;
    seq_state_t      st_d, st_q;

    pcs_select u_sel (
        .cyc_en    (cyc_en),
        .call_en   (call_en),
        .ret_en    (ret_en),
        .jmp_en    (jmp_en),
        .pcl_wr_en (pcl_wr_en),
        .sel       (sel)
    );

    pcs_target #(.MEM_WORDS(MEM_WORDS)) u_tgt (
        .sel        (sel),
        .pc_cur     (st_q.pc),
        .page_sel   (page_sel),
        .jmp_field  (jmp_field),
        .call_field (call_field),
        .pcl_data   (pcl_data),
        .stk_top    (stk_lvl1),
        .pc_next    (pc_next)
    );

    assign do_push = rst_n && (sel == SEL_CALL);
    assign do_pop  = rst_n && (sel == SEL_RET);

    pcs_ret_stack u_stk (
        .clk      (clk),
        .push     (do_push),
        .pop      (do_pop),
        .push_val (st_q.pc),
        .lvl1     (stk_lvl1),
        .lvl2     (stk_lvl2)
    );

    always_comb begin
        st_d = st_q;
        if (sel != SEL_HOLD) begin
            st_d.pc    = pc_next;
            st_d.flush = (sel != SEL_INC);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.pc    <= RESET_PC;
            st_q.flush <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fetch_addr = st_q.pc;
    assign flush      = st_q.flush;
    assign wreg_we    = (sel == SEL_RET);
    assign wreg_lit   = ret_lit;

    logic unused_lvl2;
    assign unused_lvl2 = ^stk_lvl2;
endmodule

// File: rtl/pc_sequencer_chk.sv
module pc_sequencer_chk
    import pcs_pkg::*;
#(
    parameter int MEM_WORDS = 1024
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cyc_en,
    input logic              jmp_en,
    input logic [JMP_W-1:0]  jmp_field,
    input logic              call_en,
    input logic              ret_en,
    input logic              pcl_wr_en,
    input logic [PC_W-1:0]   fetch_addr,
    input logic              flush
);
    localparam logic [PC_W-1:0] ADDR_MASK = PC_W'(MEM_WORDS - 1);

    logic any_strobe;
    assign any_strobe = call_en || ret_en || jmp_en || pcl_wr_en;

    a_r1_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_addr & ~ADDR_MASK) == '0);

    a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_en && !any_strobe) |=>
        fetch_addr == (($past(fetch_addr) + PC_W'(1)) & ADDR_MASK));

    a_r3_jump_low: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_en && jmp_en && !call_en && !ret_en) |=>
        fetch_addr[JMP_W-1:0] == ($past(PC_W'(jmp_field)) & ADDR_MASK) & PC_W'(9'h1FF));

    a_r4_call_bit8: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_en && call_en) |=> fetch_addr[8] == 1'b0);

    a_r9_flush_set: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_en && any_strobe) |=> flush);

    a_r9_flush_clr: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_en && !any_strobe) |=> !flush);

    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_en |=> ($stable(fetch_addr) && $stable(flush)));
endmodule

bind pc_sequencer pc_sequencer_chk #(.MEM_WORDS(MEM_WORDS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cyc_en     (cyc_en),
    .jmp_en     (jmp_en),
    .jmp_field  (jmp_field),
    .call_en    (call_en),
    .ret_en     (ret_en),
    .pcl_wr_en  (pcl_wr_en),
    .fetch_addr (fetch_addr),
    .flush      (flush)
);

// File: tb/pc_sequencer_test.sv
module pc_sequencer_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cyc_en = 1'b0;
    logic        page_sel = 1'b0;
    logic        jmp_en = 1'b0;
    logic [8:0]  jmp_field = '0;
    logic        call_en = 1'b0;
    logic [7:0]  call_field = '0;
    logic        ret_en = 1'b0;
    logic [7:0]  ret_lit = '0;
    logic        pcl_wr_en = 1'b0;
    logic [7:0]  pcl_data = '0;

    logic [11:0] addr_a, addr_b;
    logic        fl_a, fl_b, we_a, we_b;
    logic [7:0]  lit_a, lit_b;

    int n_checks = 0;
    int n_fail   = 0;

    logic [11:0] m_pc [2];
    logic [11:0] m_s1 [2];
    logic [11:0] m_s2 [2];
    logic        m_fl [2];
    logic [11:0] m_mask [2];

    always #(CLK_PERIOD/2) clk = ~clk;

    pc_sequencer #(.MEM_WORDS(1024)) uut (
        .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .page_sel(page_sel),
        .jmp_en(jmp_en), .jmp_field(jmp_field), .call_en(call_en),
        .call_field(call_field), .ret_en(ret_en), .ret_lit(ret_lit),
        .pcl_wr_en(pcl_wr_en), .pcl_data(pcl_data),
        .fetch_addr(addr_a), .flush(fl_a), .wreg_we(we_a), .wreg_lit(lit_a)
    );

    pc_sequencer #(.MEM_WORDS(512)) uut_small (
        .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .page_sel(page_sel),
        .jmp_en(jmp_en), .jmp_field(jmp_field), .call_en(call_en),
        .call_field(call_field), .ret_en(ret_en), .ret_lit(ret_lit),
        .pcl_wr_en(pcl_wr_en), .pcl_data(pcl_data),
        .fetch_addr(addr_b), .flush(fl_b), .wreg_we(we_b), .wreg_lit(lit_b)
    );

    task automatic check(input string tag, input logic [11:0] act, input logic [11:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // One instruction cycle: drive, check the same-cycle literal outputs,
    // update the model, then check address and flush after the edge.
    task automatic cycle(input string tag, input logic en, input logic c, input logic r,
                         input logic j, input logic p, input logic pg,
                         input logic [8:0] jf, input logic [7:0] cb,
                         input logic [7:0] pb, input logic [7:0] rl);
        logic exp_we;
        cyc_en = en; call_en = c; ret_en = r; jmp_en = j; pcl_wr_en = p;
        page_sel = pg; jmp_field = jf; call_field = cb; pcl_data = pb; ret_lit = rl;
        #1;
        exp_we = en && r && !c;
        check("R7 wreg_we", {11'd0, we_a}, {11'd0, exp_we});
        check("R7 wreg_we small", {11'd0, we_b}, {11'd0, exp_we});
        if (exp_we) check("R7 wreg_lit", {4'd0, lit_a}, {4'd0, rl});
        for (int k = 0; k < 2; k++) begin
            if (en) begin
                m_fl[k] = c || r || j || p;
                if (c) begin
                    m_s2[k] = m_s1[k];
                    m_s1[k] = m_pc[k];
                    m_pc[k] = 12'({pg, 1'b0, cb}) & m_mask[k];
                end else if (r) begin
                    m_pc[k] = m_s1[k];
                    m_s1[k] = m_s2[k];
                end else if (j) begin
                    m_pc[k] = 12'({pg, jf}) & m_mask[k];
                end else if (p) begin
                    m_pc[k] = 12'({pg, 1'b0, pb}) & m_mask[k];
                end else begin
                    m_pc[k] = (m_pc[k] + 12'd1) & m_mask[k];
                end
            end
        end
        @(posedge clk); #1;
        check(tag, addr_a, m_pc[0]);
        check(tag, addr_b, m_pc[1]);
        check("R9 flush", {11'd0, fl_a}, {11'd0, m_fl[0]});
        check("R9 flush small", {11'd0, fl_b}, {11'd0, m_fl[1]});
    endtask

    task automatic plain(input string tag);
        cycle(tag, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 9'd0, 8'd0, 8'd0, 8'd0);
    endtask

    task automatic do_reset();
        cyc_en = 1'b0; call_en = 1'b0; ret_en = 1'b0; jmp_en = 1'b0; pcl_wr_en = 1'b0;
        rst_n = 1'b0;
        #1;
        for (int k = 0; k < 2; k++) begin
            m_pc[k] = m_mask[k];
            m_fl[k] = 1'b0;
        end
        check("R8 reset addr", addr_a, 12'h3FF);
        check("R8 reset addr small", addr_b, 12'h1FF);
        check("R8 reset flush", {11'd0, fl_a}, 12'd0);
        @(posedge clk); #1;
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        m_mask[0] = 12'h3FF;
        m_mask[1] = 12'h1FF;
        for (int k = 0; k < 2; k++) begin
            m_s1[k] = '0; m_s2[k] = '0; m_fl[k] = 1'b0; m_pc[k] = m_mask[k];
        end
        repeat (2) @(posedge clk);
        #1;
        // R8: state held in reset
        check("R8 reset addr", addr_a, 12'h3FF);
        check("R8 reset addr small", addr_b, 12'h1FF);
        check("R8 reset flush", {11'd0, fl_a}, 12'd0);
        rst_n = 1'b1;

        // R1, R2: increments across both wrap points
        for (int i = 0; i < 1100; i++) plain("R2 increment/R1 wrap");

        // R3: every jump field with both page values
        for (int pg = 0; pg < 2; pg++)
            for (int f = 0; f < 512; f++)
                cycle("R3 jump", 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, pg[0], f[8:0], 8'd0, 8'd0, 8'd0);

        // R11: strobes ignored while disabled, flush high and low
        cycle("R11 hold flush high", 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 9'h155, 8'hAA, 8'h55, 8'h11);
        plain("R2 increment");
        cycle("R11 hold flush low", 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 9'h0AA, 8'h3C, 8'hC3, 8'h22);

        // R4: every byte for calls and low-byte writes with both pages
        for (int pg = 0; pg < 2; pg++)
            for (int b = 0; b < 256; b++) begin
                cycle("R4 call", 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, pg[0], 9'd0, b[7:0], 8'd0, 8'd0);
                cycle("R4 low-byte write", 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, pg[0], 9'd0, 8'd0, b[7:0], 8'd0);
            end

        // R5, R6, R7: three nested calls, four returns
        cycle("R3 jump", 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 9'h010, 8'd0, 8'd0, 8'd0);
        plain("R2 increment");
        cycle("R5 call 1", 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 9'd0, 8'h40, 8'd0, 8'd0);
        plain("R2 increment");
        cycle("R5 call 2", 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 9'd0, 8'h80, 8'd0, 8'd0);
        plain("R2 increment");
        cycle("R5 call 3", 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 9'd0, 8'hC0, 8'd0, 8'd0);
        cycle("R6 return 1", 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 9'd0, 8'd0, 8'd0, 8'h5A);
        cycle("R6 return 2", 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 9'd0, 8'd0, 8'd0, 8'hA5);
        cycle("R6 return 3 repeats", 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 9'd0, 8'd0, 8'd0, 8'h00);
        cycle("R6 return 4 repeats", 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 9'd0, 8'd0, 8'd0, 8'hFF);

        // R10: priority among simultaneous strobes
        cycle("R10 call wins", 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 9'h1F0, 8'h21, 8'h42, 8'h63);
        cycle("R10 return wins", 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 9'h1F0, 8'h21, 8'h42, 8'h77);
        cycle("R10 jump wins", 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 9'h1F0, 8'h21, 8'h42, 8'h00);
        cycle("R10 write alone", 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 9'h1F0, 8'h21, 8'h42, 8'h00);

        // R8: reset keeps the stack
        cycle("R5 call", 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 9'd0, 8'h12, 8'd0, 8'd0);
        plain("R2 increment");
        cycle("R5 call", 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 9'd0, 8'h34, 8'd0, 8'd0);
        do_reset();
        plain("R8 first step after reset");
        cycle("R8 stack kept, return 1", 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 9'd0, 8'd0, 8'd0, 8'h01);
        cycle("R8 stack kept, return 2", 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 9'd0, 8'd0, 8'd0, 8'h02);
        plain("R2 increment");

        summary();
    end
endmodule